// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits between a group of cores and an uncached memory, and every read and write from the cores passes through it. Each core offers a request that carries an operation kind, an address and write data. The monitor picks one request per cycle, sends it on to memory and returns the response to the chosen core in the same cycle. It keeps one address reservation for each core. It uses these reservations to decide whether a store-conditional is allowed to write.

A load-linked reads memory and records a reservation for its core. Any write that reaches memory at a reserved address, from a different core, cancels that reservation. A store-conditional writes only when its core still holds a reservation for the same address. When the check fails, no memory access is made at all, and the core receives a status bit of 0. Cores keep their request asserted until they are granted. The memory is expected to answer reads combinationally.

Top module: `llscMonitor`

## Requirements
- R1: After reset no core holds a reservation, so a store-conditional issued first fails. With no request pending, reqGrant is 0 and memValid is 0.
- R2: Each cycle exactly one requesting core is granted, and it is the one with the lowest index. reqGrant is one-hot or zero, and it is never set for a core that is not requesting.
- R3: A plain load (type 0) reads memory and returns memRdata on rspData. A plain store (type 1) writes reqWdata to memory and returns 0.
- R4: A load-linked (type 2) reads memory like a load and sets the core's reservation to that address. A later load-linked from the same core replaces the earlier reservation.
- R5: A store-conditional (type 3) whose core holds a reservation for the same address writes memory and returns 1 in rspData bit 0, with all other bits 0.
- R6: A store-conditional with no reservation, or with a reservation for a different address, makes no memory access (memValid stays 0) and returns 0.
- R7: A write that reaches memory (a store or a successful store-conditional) clears the reservation of every other core that holds that address.
- R8: Every store-conditional clears its own core's reservation, whether it succeeds or fails. A core's own plain store leaves its own reservation in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_CORES | Request pending, one bit per core |
| reqType | input | 2*NUM_CORES | Operation kind per core: 0 load, 1 store, 2 load-linked, 3 store-conditional |
| reqAddr | input | NUM_CORES*ADDR_W | Address per core |
| reqWdata | input | NUM_CORES*DATA_W | Write data per core |
| reqGrant | output | NUM_CORES | One-hot grant; the response is valid for the granted core in this cycle |
| rspData | output | DATA_W | Read data, or the store-conditional status in bit 0 |
| memValid | output | 1 | Memory access this cycle |
| memWrite | output | 1 | Access is a write |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data, combinational |

## Verification
Directed sequences run one core at a time. They separate a store-conditional that succeeds from one that fails for each distinct cause: no reservation yet, a reservation already consumed, a reservation for another address, and a reservation taken away by another core's store or by another core's successful store-conditional. One sequence puts a core's own store between its load-linked and its store-conditional, which shows that own writes do not cancel. Another issues two load-linked operations in a row, which shows that the second replaces the first. A simultaneous request from several cores exposes the arbitration order. A long random run follows in which four cores compete over four addresses, with requests held until granted. A behavioural model checks grant, memory traffic and response on every cycle of this run.

// File: rtl/llscPkg.sv
package llscPkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LL    = 2'd2,
    OP_SC    = 2'd3
  } opE;

  // Strobes from control to the reservation datapath
  typedef struct packed {
    logic active;   // some core is granted this cycle
    logic llSet;    // granted core takes a reservation
    logic scUse;    // granted core consumes its reservation
    logic wrClear;  // a write reaches memory: drop matching reservations of other cores
  } strobeT;
endpackage

// File: rtl/llscData.sv
module llscData
  import llscPkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CORES-1:0]          grant,
  input  logic [IDX_W-1:0]              grantIdx,
  input  strobeT                        st,
  input  logic [NUM_CORES*ADDR_W-1:0]   reqAddr,
  input  logic [NUM_CORES*DATA_W-1:0]   reqWdata,
  output logic [ADDR_W-1:0]             selAddr,
  output logic [DATA_W-1:0]             selWdata,
  output logic                          ownMatch
);
  logic [NUM_CORES-1:0] resValid;
  logic [ADDR_W-1:0]    resAddr [NUM_CORES];

  assign selAddr  = reqAddr[int'(grantIdx)*ADDR_W +: ADDR_W];
  assign selWdata = reqWdata[int'(grantIdx)*DATA_W +: DATA_W];
  assign ownMatch = st.active && resValid[grantIdx] && (resAddr[grantIdx] == selAddr);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_res
    logic hitOther;
    assign hitOther = st.wrClear && !grant[c] && resValid[c] && (resAddr[c] == selAddr);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        resValid[c] <= 1'b0;
        resAddr[c]  <= '0;
      end else if (grant[c] && st.llSet) begin
        resValid[c] <= 1'b1;
        resAddr[c]  <= selAddr;
      end else if (grant[c] && st.scUse) begin
        resValid[c] <= 1'b0;
      end else if (hitOther) begin
        resValid[c] <= 1'b0;
      end
    end

    assert_ll_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
      (grant[c] && st.llSet) |=> (resValid[c] && resAddr[c] == $past(selAddr)));

    assert_sc_consumes_R8: assert property (@(posedge clk) disable iff (!rstN)
      (grant[c] && st.scUse) |=> !resValid[c]);

    assert_other_write_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
      (st.wrClear && !grant[c] && resValid[c] && resAddr[c] == selAddr) |=> !resValid[c]);
  end
endmodule

// File: rtl/llscCtrl.sv
module llscCtrl
  import llscPkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CORES-1:0]     reqValid,
  input  logic [2*NUM_CORES-1:0]   reqType,
  input  logic                     ownMatch,
  output logic [NUM_CORES-1:0]     grant,
  output logic [IDX_W-1:0]         grantIdx,
  output strobeT                   st,
  output logic                     memValid,
  output logic                     memWrite,
  output logic                     rspFromMem,
  output logic                     scOk
);
  opE op;

  // Fixed priority: lowest core index wins
  always_comb begin
    grant    = '0;
    grantIdx = '0;
    for (int i = NUM_CORES - 1; i >= 0; i--) begin
      if (reqValid[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        grantIdx = IDX_W'(i);
      end
    end
  end

  assign op = opE'(reqType[{grantIdx, 1'b0} +: 2]);

  always_comb begin
    st.active  = |grant;
    st.llSet   = st.active && (op == OP_LL);
    st.scUse   = st.active && (op == OP_SC);
    scOk       = st.scUse && ownMatch;
    memWrite   = st.active && ((op == OP_STORE) || scOk);
    memValid   = st.active && ((op != OP_SC) || scOk);
    st.wrClear = memWrite;
    rspFromMem = (op == OP_LOAD) || (op == OP_LL);
  end

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  assert_grant_requested_R2: assert property (@(posedge clk) disable iff (!rstN)
    (grant & ~reqValid) == '0);

  assert_grant_lowest_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|grant) |-> (((grant - 1'b1) & reqValid) == '0));

  assert_no_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|reqValid) |-> (|grant));
endmodule

// File: rtl/llscMonitor.sv
module llscMonitor
  import llscPkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CORES-1:0]          reqValid,
  input  logic [2*NUM_CORES-1:0]        reqType,
  input  logic [NUM_CORES*ADDR_W-1:0]   reqAddr,
  input  logic [NUM_CORES*DATA_W-1:0]   reqWdata,
  output logic [NUM_CORES-1:0]          reqGrant,
  output logic [DATA_W-1:0]             rspData,
  output logic                          memValid,
  output logic                          memWrite,
  output logic [ADDR_W-1:0]             memAddr,
  output logic [DATA_W-1:0]             memWdata,
  input  logic [DATA_W-1:0]             memRdata
);
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  logic [IDX_W-1:0] grantIdx;
  strobeT           st;
  logic             ownMatch;
  logic             rspFromMem;
  logic             scOk;

  llscCtrl #(.NUM_CORES(NUM_CORES)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
    .ownMatch(ownMatch), .grant(reqGrant), .grantIdx(grantIdx), .st(st),
    .memValid(memValid), .memWrite(memWrite), .rspFromMem(rspFromMem), .scOk(scOk)
  );

  llscData #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_data (
    .clk(clk), .rstN(rstN), .grant(reqGrant), .grantIdx(grantIdx), .st(st),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .selAddr(memAddr),
    .selWdata(memWdata), .ownMatch(ownMatch)
  );

  assign rspData = rspFromMem ? memRdata : {{(DATA_W-1){1'b0}}, scOk};
endmodule

// File: tb/test_llscMonitor.sv
module test_llscMonitor;
  localparam int N = 4;
  localparam int A = 16;
  localparam int D = 32;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0]   reqValid = '0;
  logic [2*N-1:0] reqType  = '0;
  logic [N*A-1:0] reqAddr  = '0;
  logic [N*D-1:0] reqWdata = '0;
  logic [N-1:0]   reqGrant;
  logic [D-1:0]   rspData, memWdata, memRdata;
  logic           memValid, memWrite;
  logic [A-1:0]   memAddr;

  logic [D-1:0] memArr [16];
  logic [D-1:0] mdlMem [16];
  bit           mv [N];
  logic [A-1:0] ma [N];
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  llscMonitor #(.NUM_CORES(N), .ADDR_W(A), .DATA_W(D)) i_llscMonitor (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqGrant(reqGrant),
    .rspData(rspData), .memValid(memValid), .memWrite(memWrite),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

  assign memRdata = memArr[memAddr[3:0]];
  always_ff @(posedge clk) if (memValid && memWrite) memArr[memAddr[3:0]] <= memWdata;

  task automatic check(bit ok, string tag, string what, logic [D-1:0] act, logic [D-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Compare the current cycle with the model, then advance the model to the next edge.
  task automatic step(string tag);
    int g = -1;
    int op;
    logic [A-1:0] a;
    logic [D-1:0] w, expRsp;
    bit own, eMv, eMw;
    #1;
    for (int i = 0; i < N; i++) if (reqValid[i] && g < 0) g = i;
    check(reqGrant == ((g >= 0) ? N'(1) << g : N'(0)), (tag == "") ? "R2" : tag,
          "grant", D'(reqGrant), (g >= 0) ? D'(1) << g : '0);
    if (g < 0) begin
      check(!memValid, (tag == "") ? "R1" : tag, "idle memValid", D'(memValid), 0);
      return;
    end
    op = int'(reqType[g*2 +: 2]);
    a = reqAddr[g*A +: A];
    w = reqWdata[g*D +: D];
    own = mv[g] && ma[g] == a;
    eMw = 0; eMv = 1; expRsp = '0;
    case (op)
      0: expRsp = mdlMem[a[3:0]];                        // R3
      1: eMw = 1;                                        // R3
      2: expRsp = mdlMem[a[3:0]];                        // R4
      default: begin eMv = own; eMw = own; expRsp = D'(own); end // R5 / R6
    endcase
    if (tag == "") tag = (op == 3) ? (own ? "R5" : "R6") : (op == 2 ? "R4" : "R3");
    check(memValid == eMv, tag, "memValid", D'(memValid), D'(eMv));
    check(memWrite == eMw || !eMv, tag, "memWrite", D'(memWrite), D'(eMw));
    check(rspData == expRsp, tag, "rspData", rspData, expRsp);
    if (eMv) check(memAddr == a, tag, "memAddr", D'(memAddr), D'(a));
    if (eMw) begin
      check(memWdata == w, tag, "memWdata", memWdata, w);
      mdlMem[a[3:0]] = w;
      for (int i = 0; i < N; i++) if (i != g && mv[i] && ma[i] == a) mv[i] = 0; // R7
    end
    if (op == 2) begin mv[g] = 1; ma[g] = a; end
    if (op == 3) mv[g] = 0;                              // R8
  endtask

  task automatic one(int core, int op, int addr, logic [D-1:0] data, string tag);
    @(negedge clk);
    reqValid = '0;
    reqValid[core] = 1'b1;
    reqType[core*2 +: 2] = 2'(op);
    reqAddr[core*A +: A] = A'(addr);
    reqWdata[core*D +: D] = data;
    step(tag);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit pend [N];
    for (int i = 0; i < 16; i++) begin memArr[i] = D'(i * 3); mdlMem[i] = D'(i * 3); end
    for (int i = 0; i < N; i++) begin mv[i] = 0; ma[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    step("R1");                                // idle after reset
    one(0, 3, 3, 32'h11, "R1");                // first SC fails
    one(1, 1, 2, 32'hAA, "R3");
    one(1, 0, 2, 0, "R3");
    one(0, 2, 2, 0, "R4");
    one(0, 3, 2, 32'h55, "R5");
    one(0, 3, 2, 32'h66, "R8");                // reservation consumed
    one(0, 2, 2, 0, "R4");
    one(2, 1, 2, 32'h77, "R7");                // other core store
    one(0, 3, 2, 32'h88, "R7");                // must fail
    one(0, 2, 2, 0, "R4");
    one(0, 1, 2, 32'h99, "R8");                // own store keeps reservation
    one(0, 3, 2, 32'h9A, "R8");                // succeeds
    one(0, 2, 1, 0, "R4");
    one(0, 2, 2, 0, "R4");                     // replaces
    one(0, 3, 1, 32'hBB, "R6");                // address mismatch
    one(0, 2, 5, 0, "R4");
    one(1, 2, 5, 0, "R4");
    one(0, 3, 5, 32'hCC, "R5");
    one(1, 3, 5, 32'hDD, "R7");                // lost to other core's SC
    one(0, 0, 5, 0, "R3");
    @(negedge clk);
    reqValid = 4'b1110;
    for (int i = 0; i < N; i++) begin reqType[i*2 +: 2] = 2'd0; reqAddr[i*A +: A] = A'(i); end
    step("R2");
    // random contention phase
    for (int i = 0; i < N; i++) pend[i] = 0;
    reqValid = '0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        if (!pend[i] && ($urandom % 2) == 1) begin
          pend[i] = 1;
          reqType[i*2 +: 2] = 2'($urandom % 4);
          reqAddr[i*A +: A] = A'($urandom % 4);
          reqWdata[i*D +: D] = $urandom;
        end
        reqValid[i] = pend[i];
      end
      step("");
      for (int i = 0; i < N; i++) if (reqGrant[i]) pend[i] = 0;
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule